// File: doc/BRIEF.md
# DMA Two-Cycle Transfer Bus Sequencer

This block sequences the bus phases of a DMA engine that moves one data unit for each accepted request. It watches four request lines, each gated by its own enable bit. When an enabled request is seen, the block steps through a ready phase and then takes one of three routes. An external transfer runs a read phase and then a write phase, and each phase can stretch on an acknowledge input. An internal RAM or peripheral target runs a single-cycle read-side phase and then the write phase. A flyby transfer runs a two-state path that moves data straight from an internal peripheral into internal RAM.

The outputs are an address-drive enable, a read strobe and a write strobe. A one-cycle capture pulse comes with the captured read word, a one-cycle done pulse marks the end of each transfer, and a 4-bit state code is always visible. The request lines are registered on the falling clock edge. The state register and the outputs change on the rising edge. A synchronous active-high reset returns everything to idle.

Top module: `dma_bus_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the state code becomes 0 (idle), and `addr_drive`, `rd_strobe`, `wr_strobe`, `capture_pulse` and `done_pulse` are all low in the following cycle.
- R2: Request lines are registered on the falling clock edge, ANDed with `chan_en`. An idle machine moves to ready (code 1) at the next rising edge after an enabled request was registered. A request on a line whose `chan_en` bit is 0 is ignored, and the machine stays idle.
- R3: From ready, the machine goes to flyby-start (code 9) if `flyby` is high. Otherwise it goes to internal-read (code 5) if `tgt_internal` is high. Otherwise it goes to read-start (code 2) if `ack` is high, or to read-wait (code 3) if `ack` is low. Read-start is always followed by read-end (code 4).
- R4: Read-wait repeats while `ack` is low and moves to read-end when `ack` is high. Read-end repeats while `ack` is low. The read-end cycle with `ack` high is its last cycle, and it is always followed by write-start (code 6).
- R5: `rd_data` is captured in the last read-end cycle or in the internal-read cycle. In the next cycle, `capture_pulse` is high for exactly one cycle and `xfer_data` holds the captured word. Read data seen in non-final read-end cycles is not kept.
- R6: Internal-read goes to write-start if `ack` is high and to write-wait (code 7) if it is low. Write-start is always followed by write-end (code 8). Write-wait repeats while `ack` is low and then moves to write-end.
- R7: Write-end repeats while `ack` is low. `wr_strobe` is high in write-wait, in write-end cycles with `ack` low, and in flyby-end. It is low in the write-end cycle with `ack` high.
- R8: Flyby-start is always followed by flyby-end (code 10). Flyby-end repeats while `ack` is low.
- R9: One cycle after the last write-end or flyby-end cycle (the one with `ack` high), `done_pulse` is high for one cycle. In that cycle the state is ready if an enabled request was still registered, and idle otherwise.
- R10: `addr_drive` is high in states 2, 3, 4, 6, 7 and 8 only. `rd_strobe` is high in states 3, 4, 5, 9 and 10 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; requests sampled on falling edge, state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | NUM_REQ | DMA request lines |
| chan_en | input | NUM_REQ | Per-line request enable mask |
| ack | input | 1 | External acknowledge; low stretches wait states |
| tgt_internal | input | 1 | Transfer targets internal RAM or peripheral |
| flyby | input | 1 | Select flyby peripheral-to-RAM path |
| rd_data | input | DATA_W | Read data from the source |
| addr_drive | output | 1 | Address bus drive enable |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| capture_pulse | output | 1 | One-cycle pulse: `xfer_data` is valid |
| xfer_data | output | DATA_W | Captured read word |
| done_pulse | output | 1 | One-cycle pulse after a finished transfer |
| state_code | output | 4 | Current phase code |

## Verification
A wrong state shows at the ports within one cycle, because the state code is an output and the strobes are decoded from the state held in the register. A wrong wait-loop decision has a lasting effect: the capture pulse, the done pulse or the final strobe drop lands one cycle early or late, and the transfers that follow stay shifted. A wrong return decision after a write shows up on the cycle of the done pulse, as a ready state where idle was expected or the reverse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 4'd0,
    ST_READY    = 4'd1,
    ST_RD_START = 4'd2,
    ST_RD_WAIT  = 4'd3,
    ST_RD_END   = 4'd4,
    ST_RD_INT   = 4'd5,
    ST_WR_START = 4'd6,
    ST_WR_WAIT  = 4'd7,
    ST_WR_END   = 4'd8,
    ST_FB_START = 4'd9,
    ST_FB_END   = 4'd10
  } seq_state_e;

  typedef struct packed {
    logic addr;
    logic rd;
    logic wr;
  } bus_ctl_t;

  // Strobe levels held for a whole phase; the write-end drop is applied later
  function automatic bus_ctl_t decode_ctl(seq_state_e s);
    bus_ctl_t c;
    c = '0;
    case (s)
      ST_RD_START: c.addr = 1'b1;
      ST_RD_WAIT:  begin c.addr = 1'b1; c.rd = 1'b1; end
      ST_RD_END:   begin c.addr = 1'b1; c.rd = 1'b1; end
      ST_RD_INT:   c.rd = 1'b1;
      ST_WR_START: c.addr = 1'b1;
      ST_WR_WAIT:  begin c.addr = 1'b1; c.wr = 1'b1; end
      ST_WR_END:   begin c.addr = 1'b1; c.wr = 1'b1; end
      ST_FB_START: c.rd = 1'b1;
      ST_FB_END:   begin c.rd = 1'b1; c.wr = 1'b1; end
      default:     c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic [NUM_REQ-1:0] enable,
  output logic               pending
);

  logic [NUM_REQ-1:0] line_q;

  // One falling-edge flop per request line
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
    logic bit_q;
    always_ff @(negedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= req[i] & enable[i];
    end
    assign line_q[i] = bit_q;
  end

  assign pending = |line_q;

endmodule

// File: rtl/dma_phase_next.sv
module dma_phase_next
  import dma_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic       pending,
  input  logic       ack,
  input  logic       tgt_internal,
  input  logic       flyby,
  output seq_state_e nxt
);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (pending) nxt = ST_READY;
      ST_READY: begin
        if (flyby)             nxt = ST_FB_START;
        else if (tgt_internal) nxt = ST_RD_INT;
        else if (ack)          nxt = ST_RD_START;
        else                   nxt = ST_RD_WAIT;
      end
      ST_RD_START: nxt = ST_RD_END;
      ST_RD_WAIT:  if (ack) nxt = ST_RD_END;
      ST_RD_END:   if (ack) nxt = ST_WR_START;
      ST_RD_INT:   nxt = ack ? ST_WR_START : ST_WR_WAIT;
      ST_WR_START: nxt = ST_WR_END;
      ST_WR_WAIT:  if (ack) nxt = ST_WR_END;
      ST_WR_END, ST_FB_END: begin
        if (ack) nxt = pending ? ST_READY : ST_IDLE;
      end
      ST_FB_START: nxt = ST_FB_END;
      default:     nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dma_phase_out.sv
module dma_phase_out
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  seq_state_e        nxt,
  input  logic              ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              addr_drive,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              capture_pulse,
  output logic [DATA_W-1:0] xfer_data,
  output logic              done_pulse
);

  bus_ctl_t          ctl_q;
  logic              cap_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              take_data;
  logic              finish;
  logic              wr_last;

  assign take_data = ((state == ST_RD_END) && ack) || (state == ST_RD_INT);
  assign finish    = ((state == ST_WR_END) || (state == ST_FB_END)) && ack;
  assign wr_last   = (state == ST_WR_END) && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      cap_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      ctl_q  <= decode_ctl(nxt);
      cap_q  <= take_data;
      done_q <= finish;
      if (take_data) data_q <= rd_data;
    end
  end

  assign addr_drive    = ctl_q.addr;
  assign rd_strobe     = ctl_q.rd;
  assign wr_strobe     = ctl_q.wr & ~wr_last;
  assign capture_pulse = cap_q;
  assign done_pulse    = done_q;
  assign xfer_data     = data_q;

endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
  import dma_seq_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_REQ-1:0]   dma_req,
  input  logic [NUM_REQ-1:0]   chan_en,
  input  logic                 ack,
  input  logic                 tgt_internal,
  input  logic                 flyby,
  input  logic [DATA_W-1:0]    rd_data,
  output logic                 addr_drive,
  output logic                 rd_strobe,
  output logic                 wr_strobe,
  output logic                 capture_pulse,
  output logic [DATA_W-1:0]    xfer_data,
  output logic                 done_pulse,
  output logic [STATE_W-1:0]   state_code
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       pending;

  dma_req_sampler #(.NUM_REQ(NUM_REQ)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .req     (dma_req),
    .enable  (chan_en),
    .pending (pending)
  );

  dma_phase_next u_next (
    .state        (state_q),
    .pending      (pending),
    .ack          (ack),
    .tgt_internal (tgt_internal),
    .flyby        (flyby),
    .nxt          (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  dma_phase_out #(.DATA_W(DATA_W)) u_out (
    .clk           (clk),
    .rst           (rst),
    .state         (state_q),
    .nxt           (rst ? ST_IDLE : state_d),
    .ack           (ack),
    .rd_data       (rd_data),
    .addr_drive    (addr_drive),
    .rd_strobe     (rd_strobe),
    .wr_strobe     (wr_strobe),
    .capture_pulse (capture_pulse),
    .xfer_data     (xfer_data),
    .done_pulse    (done_pulse)
  );

  assign state_code = state_q;

endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker
  import dma_seq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               addr_drive,
  input logic               wr_strobe,
  input logic               capture_pulse,
  input logic               done_pulse,
  input logic [STATE_W-1:0] state_code
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (state_code == ST_IDLE));

  assert_rd_start_to_end_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_RD_START) |=> (state_code == ST_RD_END));

  assert_rd_end_waits_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_RD_END && !ack) |=> (state_code == ST_RD_END));

  assert_capture_source_R5: assert property (@(posedge clk) disable iff (rst)
    capture_pulse |-> ($past(state_code) == ST_RD_INT ||
                       ($past(state_code) == ST_RD_END && $past(ack))));

  assert_wr_start_to_end_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_WR_START) |=> (state_code == ST_WR_END));

  assert_wr_strobe_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_WR_END && ack) |-> !wr_strobe);

  assert_flyby_start_to_end_R8: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_FB_START) |=> (state_code == ST_FB_END));

  assert_done_lands_R9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (state_code == ST_IDLE || state_code == ST_READY));

  assert_no_addr_internal_R10: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_RD_INT || state_code == ST_FB_END) |-> !addr_drive);

endmodule

bind dma_bus_sequencer dma_seq_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .ack           (ack),
  .addr_drive    (addr_drive),
  .wr_strobe     (wr_strobe),
  .capture_pulse (capture_pulse),
  .done_pulse    (done_pulse),
  .state_code    (state_code)
);

// File: tb/dma_bus_sequencer_bench.sv
`timescale 1ns/1ps
module dma_bus_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dma_req = '0;
  logic [3:0]  chan_en = 4'b1111;
  logic        ack = 1'b0;
  logic        tgt_internal = 1'b0;
  logic        flyby = 1'b0;
  logic [15:0] rd_data = '0;
  logic        addr_drive, rd_strobe, wr_strobe, capture_pulse, done_pulse;
  logic [15:0] xfer_data;
  logic [3:0]  state_code;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_bus_sequencer u_dma_bus_sequencer (
    .clk(clk), .rst(rst), .dma_req(dma_req), .chan_en(chan_en), .ack(ack),
    .tgt_internal(tgt_internal), .flyby(flyby), .rd_data(rd_data),
    .addr_drive(addr_drive), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .capture_pulse(capture_pulse), .xfer_data(xfer_data),
    .done_pulse(done_pulse), .state_code(state_code)
  );

  // Scoreboard queues, one entry per cycle
  logic [3:0]  q_st[$];
  logic        q_cap[$];
  logic        q_done[$];
  logic        q_ack[$];
  logic [15:0] q_data[$];
  string       q_tag[$];

  // Expected {addr, rd, wr} per state code, from R10 and R7
  function automatic logic [2:0] exp_ctl(logic [3:0] st, logic a);
    case (st)
      4'd2:  return 3'b100;
      4'd3:  return 3'b110;
      4'd4:  return 3'b110;
      4'd5:  return 3'b010;
      4'd6:  return 3'b100;
      4'd7:  return 3'b101;
      4'd8:  return {2'b10, ~a};
      4'd9:  return 3'b010;
      4'd10: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  task automatic step(input logic a, input logic [3:0] rq, input logic [15:0] rdd,
                      input logic [3:0] st, input logic cap, input logic dn,
                      input logic [15:0] edata, input string tag);
    @(posedge clk);
    #1;
    ack = a; dma_req = rq; rd_data = rdd;
    q_st.push_back(st); q_cap.push_back(cap); q_done.push_back(dn);
    q_ack.push_back(a); q_data.push_back(edata); q_tag.push_back(tag);
  endtask

  // Monitor: compares mid-cycle, after the falling edge
  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (q_st.size() > 0) begin
        logic [3:0]  est;
        logic        ecap, edn, ea;
        logic [15:0] edat;
        logic [2:0]  ectl;
        string       tg;
        bit          bad;
        est = q_st.pop_front(); ecap = q_cap.pop_front(); edn = q_done.pop_front();
        ea = q_ack.pop_front(); edat = q_data.pop_front(); tg = q_tag.pop_front();
        ectl = exp_ctl(est, ea);
        bad = 1'b0;
        n_checks++;
        if (state_code !== est) begin
          bad = 1'b1;
          $display("FAIL %s state: actual %0d expected %0d", tg, state_code, est);
        end
        if ({addr_drive, rd_strobe, wr_strobe} !== ectl) begin
          bad = 1'b1;
          $display("FAIL %s strobes addr/rd/wr: actual %b expected %b", tg,
                   {addr_drive, rd_strobe, wr_strobe}, ectl);
        end
        if (capture_pulse !== ecap) begin
          bad = 1'b1;
          $display("FAIL %s capture_pulse: actual %b expected %b", tg, capture_pulse, ecap);
        end
        if (done_pulse !== edn) begin
          bad = 1'b1;
          $display("FAIL %s done_pulse: actual %b expected %b", tg, done_pulse, edn);
        end
        if (ecap && xfer_data !== edat) begin
          bad = 1'b1;
          $display("FAIL %s xfer_data: actual %h expected %h", tg, xfer_data, edat);
        end
        if (bad) n_fail++;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(0, 4'h0, 16'h0, 4'd0, 0, 0, 16'h0, "R1");
    step(0, 4'h0, 16'h0, 4'd0, 0, 0, 16'h0, "R1");
    rst = 1'b0;

    // External transfer with waits on both sides
    step(0, 4'b0001, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0001, 16'h0,    4'd1, 0, 0, 16'h0,    "R2");
    step(0, 4'b0001, 16'h0,    4'd3, 0, 0, 16'h0,    "R3");
    step(1, 4'b0001, 16'h0,    4'd3, 0, 0, 16'h0,    "R4");
    step(0, 4'b0001, 16'h1111, 4'd4, 0, 0, 16'h0,    "R4");
    step(1, 4'b0000, 16'hA5C3, 4'd4, 0, 0, 16'h0,    "R4");
    step(0, 4'b0000, 16'h0,    4'd6, 1, 0, 16'hA5C3, "R5");
    step(0, 4'b0000, 16'h0,    4'd8, 0, 0, 16'h0,    "R7");
    step(1, 4'b0000, 16'h0,    4'd8, 0, 0, 16'h0,    "R7");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 1, 16'h0,    "R9");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 0, 16'h0,    "R9");

    // Masked request ignored, then internal target back-to-back
    chan_en = 4'b0101;
    step(0, 4'b0010, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0010, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0010, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    tgt_internal = 1'b1;
    step(0, 4'b0100, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0100, 16'h0,    4'd1, 0, 0, 16'h0,    "R3");
    step(0, 4'b0100, 16'hBEEF, 4'd5, 0, 0, 16'h0,    "R6");
    step(0, 4'b0100, 16'h0,    4'd7, 1, 0, 16'hBEEF, "R5");
    step(1, 4'b0100, 16'h0,    4'd7, 0, 0, 16'h0,    "R6");
    step(1, 4'b0100, 16'h0,    4'd8, 0, 0, 16'h0,    "R7");
    step(1, 4'b0100, 16'h0,    4'd1, 0, 1, 16'h0,    "R9");
    step(1, 4'b0100, 16'h0042, 4'd5, 0, 0, 16'h0,    "R6");
    step(0, 4'b0000, 16'h0,    4'd6, 1, 0, 16'h0042, "R5");
    step(1, 4'b0000, 16'h0,    4'd8, 0, 0, 16'h0,    "R7");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 1, 16'h0,    "R9");
    tgt_internal = 1'b0;
    chan_en = 4'b1111;

    // External, ack already high at ready: read-start path
    step(1, 4'b1000, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(1, 4'b1000, 16'h0,    4'd1, 0, 0, 16'h0,    "R3");
    step(0, 4'b1000, 16'h0,    4'd2, 0, 0, 16'h0,    "R10");
    step(1, 4'b0000, 16'h7E01, 4'd4, 0, 0, 16'h0,    "R3");
    step(1, 4'b0000, 16'h0,    4'd6, 1, 0, 16'h7E01, "R5");
    step(1, 4'b0000, 16'h0,    4'd8, 0, 0, 16'h0,    "R7");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 1, 16'h0,    "R9");

    // Flyby path
    flyby = 1'b1;
    step(0, 4'b0001, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0001, 16'h0,    4'd1, 0, 0, 16'h0,    "R3");
    step(0, 4'b0000, 16'h0,    4'd9, 0, 0, 16'h0,    "R8");
    step(0, 4'b0000, 16'h0,    4'd10, 0, 0, 16'h0,   "R8");
    step(1, 4'b0000, 16'h0,    4'd10, 0, 0, 16'h0,   "R8");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 1, 16'h0,    "R9");
    flyby = 1'b0;

    // Reset in the middle of a read wait
    step(0, 4'b0001, 16'h0,    4'd0, 0, 0, 16'h0,    "R2");
    step(0, 4'b0001, 16'h0,    4'd1, 0, 0, 16'h0,    "R3");
    step(0, 4'b0001, 16'h0,    4'd3, 0, 0, 16'h0,    "R3");
    rst = 1'b1;
    step(0, 4'b0000, 16'h0,    4'd0, 0, 0, 16'h0,    "R1");
    rst = 1'b0;
    step(0, 4'b0000, 16'h0,    4'd0, 0, 0, 16'h0,    "R1");
    step(0, 4'b0000, 16'h0,    4'd0, 0, 0, 16'h0,    "R1");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule